// File: doc/BRIEF.md
# Next Fetch Address Unit with Branch Delay Slot

This unit keeps the fetch address of a 32-bit load/store style core whose control transfers have one delay slot. Each cycle the decoder reports the class of the instruction sitting at the current fetch address: plain sequential, absolute jump, jump that also saves a return address, or jump through a register value. The unit returns the address to fetch next, tells the core whether the instruction now in flight is a delay slot, and requests the write of the return address to register 31 when a linking jump is decoded.

A redirect never takes effect at once. The instruction after a control transfer is always fetched and issued, exactly once, and only the fetch after it goes to the target. The return address therefore points past the delay slot: it is the jump's own address plus 8, built from two steps of 4. A return through the register then resumes after the slot without running it a second time. Instruction memory, the register file and branch conditions sit outside the unit.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, pc_o equals RESET_VEC (default 32'hBFC0_0000), in_slot_o is 0 and link_we_o is 0, whatever the class input holds.
- R2: In a cycle that is not a delay slot, npc_o equals pc_o + 4 and pc_o takes that value at the next clock edge. Class code 0 means sequential.
- R3: A control class (code 1 absolute jump, 2 linking jump, 3 register jump) outside a delay slot makes the next fetched address pc_o + 4 with in_slot_o at 1. That slot is issued exactly once, and the fetch after it is the target.
- R4: The target of codes 1 and 2 is {bits 31:28 of the delay-slot address (pc_o + 4), jidx_i, 2'b00}. The upper bits come from the slot, not from the jump.
- R5: A code 2 instruction outside a slot asserts link_we_o in its own cycle, with link_addr_o = 31 and link_val_o = pc_o + 8.
- R6: The target of code 3 is rs_val_i as sampled in the jump's cycle. rs_val_i during the delay slot has no effect on the target.
- R7: align_err_o is 1 in the cycle of a code 3 instruction outside a slot exactly when rs_val_i[1:0] is not 0. The target keeps those low bits unchanged.
- R8: A control class decoded in a delay slot is treated as sequential for its own effects: no link write, no alignment flag and no new redirect. The fetch after the slot still goes to the earlier target.
- R9: After a linking jump, a register jump to the saved link value resumes fetch at the jump address + 8, so the delay slot is not issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_class_i | input | 2 | Class of the instruction at pc_o: 0 seq, 1 jump, 2 jump-and-link, 3 jump-register |
| jidx_i | input | 26 | Word index field of an absolute jump |
| rs_val_i | input | 32 | Register value used as the target of a register jump |
| pc_o | output | 32 | Address of the instruction issued this cycle |
| npc_o | output | 32 | Address to fetch in the next cycle |
| link_we_o | output | 1 | Return-address write request |
| link_addr_o | output | 5 | Register receiving the return address (31) |
| link_val_o | output | 32 | Return address, pc_o + 8 |
| in_slot_o | output | 1 | The instruction at pc_o is a delay slot |
| align_err_o | output | 1 | Register jump target is not word aligned |

## Verification
The bench runs every three-instruction sequence of classes after reset. This covers back-to-back jumps, where a design that honoured a jump in the slot would fetch the wrong target or write a spurious link. A jump placed in the last word of an address region catches a design that takes the upper target bits from the jump rather than from the slot, which would land 256 MiB away. A return through a saved link value shows whether the slot runs twice, as it would with a PC+4 link. Changing the register value during the slot catches a design that samples the register target late. All four low-bit patterns of a register target check the alignment flag, which a wrong design would also let rewrite the address.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      CC_SEQ = 2'd0,
      CC_JMP = 2'd1,
      CC_JAL = 2'd2,
      CC_JR  = 2'd3
   } ctl_class_e;

   localparam int unsigned CLASS_W = 2;
endpackage

// File: rtl/npc_incr.sv
// Two chained fixed-step adders: fetch increment and link increment.
module npc_incr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 4
) (
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] seq_o,
   output logic [ADDR_W-1:0] link_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   assign seq_o  = pc_i + STEP_V;
   assign link_o = seq_o + STEP_V;
endmodule

// File: rtl/npc_target.sv
// Forms the redirect address for absolute and register jumps.
module npc_target #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 26,
   parameter bit          ALIGN_CHECK = 1'b1
) (
   input  logic [ADDR_W-1:0] slot_addr_i,
   input  logic [IDX_W-1:0]  jidx_i,
   input  logic [ADDR_W-1:0] rs_val_i,
   input  logic              use_reg_i,
   input  logic              reg_valid_i,
   output logic [ADDR_W-1:0] target_o,
   output logic              align_err_o
);
   localparam int unsigned REGION_W = ADDR_W - IDX_W - 2;

   logic [ADDR_W-1:0] abs_tgt;

   assign abs_tgt  = {slot_addr_i[ADDR_W-1 -: REGION_W], jidx_i, 2'b00};
   assign target_o = use_reg_i ? rs_val_i : abs_tgt;

   generate
      if (ALIGN_CHECK) begin : g_align
         assign align_err_o = reg_valid_i & (|rs_val_i[1:0]);
      end else begin : g_no_align
         assign align_err_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/npc_slot_tracker.sv
// Holds the fetch address, the delay-slot flag and the pending target.
module npc_slot_tracker #(
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect_i,
   input  logic [ADDR_W-1:0] redirect_tgt_i,
   input  logic [ADDR_W-1:0] seq_pc_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic              in_slot_o
);
   logic [ADDR_W-1:0] pend_tgt_q;

   assign npc_o = in_slot_o ? pend_tgt_q : seq_pc_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o       <= RESET_VEC;
         in_slot_o  <= 1'b0;
         pend_tgt_q <= '0;
      end else begin
         pc_o      <= npc_o;
         in_slot_o <= redirect_i;
         if (redirect_i) begin
            pend_tgt_q <= redirect_tgt_i;
         end
      end
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       IDX_W       = 26,
   parameter int unsigned       INSN_BYTES  = 4,
   parameter int unsigned       REG_IDX_W   = 5,
   parameter int unsigned       LINK_REG    = 31,
   parameter bit                ALIGN_CHECK = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_VEC   = 32'hBFC0_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           ctl_class_i,
   input  logic [IDX_W-1:0]     jidx_i,
   input  logic [ADDR_W-1:0]    rs_val_i,
   output logic [ADDR_W-1:0]    pc_o,
   output logic [ADDR_W-1:0]    npc_o,
   output logic                 link_we_o,
   output logic [REG_IDX_W-1:0] link_addr_o,
   output logic [ADDR_W-1:0]    link_val_o,
   output logic                 in_slot_o,
   output logic                 align_err_o
);
   import npc_pkg::*;

   localparam int unsigned REGION_W = ADDR_W - IDX_W - 2;

   if (IDX_W + 2 >= ADDR_W) begin : g_bad_idx
      $error("npc_unit: IDX_W leaves no region bits");
   end
   if (INSN_BYTES != 4) begin : g_bad_step
      $error("npc_unit: only 4-byte instructions are supported");
   end
   if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
      $error("npc_unit: LINK_REG does not fit REG_IDX_W");
   end
   if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("npc_unit: RESET_VEC must be word aligned");
   end

   ctl_class_e        cls;
   logic              honored;
   logic              redirect;
   logic              is_link;
   logic              is_reg;
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] link_pc;
   logic [ADDR_W-1:0] tgt;
   logic              aerr;

   assign cls      = ctl_class_e'(ctl_class_i);
   assign honored  = rst_n & ~in_slot_o;
   assign redirect = honored & (cls != CC_SEQ);
   assign is_link  = honored & (cls == CC_JAL);
   assign is_reg   = honored & (cls == CC_JR);

   npc_incr #(
      .ADDR_W (ADDR_W),
      .STEP   (INSN_BYTES)
   ) u_incr (
      .pc_i   (pc_o),
      .seq_o  (seq_pc),
      .link_o (link_pc)
   );

   npc_target #(
      .ADDR_W      (ADDR_W),
      .IDX_W       (IDX_W),
      .ALIGN_CHECK (ALIGN_CHECK)
   ) u_target (
      .slot_addr_i (seq_pc),
      .jidx_i      (jidx_i),
      .rs_val_i    (rs_val_i),
      .use_reg_i   (cls == CC_JR),
      .reg_valid_i (is_reg),
      .target_o    (tgt),
      .align_err_o (aerr)
   );

   npc_slot_tracker #(
      .ADDR_W    (ADDR_W),
      .RESET_VEC (RESET_VEC)
   ) u_track (
      .clk            (clk),
      .rst_n          (rst_n),
      .redirect_i     (redirect),
      .redirect_tgt_i (tgt),
      .seq_pc_i       (seq_pc),
      .pc_o           (pc_o),
      .npc_o          (npc_o),
      .in_slot_o      (in_slot_o)
   );

   assign link_we_o   = is_link;
   assign link_addr_o = REG_IDX_W'(LINK_REG);
   assign link_val_o  = link_pc;
   assign align_err_o = aerr;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned REG_IDX_W = 5,
   parameter int unsigned LINK_REG  = 31
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           ctl_class_i,
   input logic [ADDR_W-1:0]    pc_o,
   input logic [ADDR_W-1:0]    npc_o,
   input logic                 link_we_o,
   input logic [REG_IDX_W-1:0] link_addr_o,
   input logic [ADDR_W-1:0]    link_val_o,
   input logic                 in_slot_o,
   input logic                 align_err_o
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!link_we_o && !in_slot_o));

   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_slot_o |=> pc_o == $past(pc_o) + ADDR_W'(4));

   p_follow_npc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pc_o == $past(npc_o));

   p_slot_after_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_slot_o && ctl_class_i != 2'd0) |=> in_slot_o);

   p_single_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_slot_o |=> !in_slot_o);

   p_link_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> (link_val_o == pc_o + ADDR_W'(8)
                     && link_addr_o == REG_IDX_W'(LINK_REG)));

   p_align_only_jr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      align_err_o |-> (ctl_class_i == 2'd3 && !in_slot_o));

   p_no_link_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_slot_o |-> (!link_we_o && !align_err_o));
endmodule

bind npc_unit npc_unit_chk #(
   .ADDR_W    (ADDR_W),
   .REG_IDX_W (REG_IDX_W),
   .LINK_REG  (LINK_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_class_i (ctl_class_i),
   .pc_o        (pc_o),
   .npc_o       (npc_o),
   .link_we_o   (link_we_o),
   .link_addr_o (link_addr_o),
   .link_val_o  (link_val_o),
   .in_slot_o   (in_slot_o),
   .align_err_o (align_err_o)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
   localparam logic [31:0] RV = 32'hBFC0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ctl_class_i = 2'd0;
   logic [25:0] jidx_i = '0;
   logic [31:0] rs_val_i = '0;
   logic [31:0] pc_o, npc_o, link_val_o;
   logic [4:0]  link_addr_o;
   logic        link_we_o, in_slot_o, align_err_o;

   int total = 0;
   int bad = 0;

   logic [31:0] m_pc;
   logic        m_slot;
   logic [31:0] m_tgt;
   logic [31:0] trace [0:15];
   int          tn;

   always #4 clk = ~clk;

   npc_unit uut (
      .clk(clk), .rst_n(rst_n), .ctl_class_i(ctl_class_i), .jidx_i(jidx_i),
      .rs_val_i(rs_val_i), .pc_o(pc_o), .npc_o(npc_o), .link_we_o(link_we_o),
      .link_addr_o(link_addr_o), .link_val_o(link_val_o),
      .in_slot_o(in_slot_o), .align_err_o(align_err_o)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ctl_class_i = 2'd2;
      #1;
      chk(pc_o, RV, "R1 pc in reset");
      chk({31'd0, in_slot_o}, 32'd0, "R1 slot in reset");
      chk({31'd0, link_we_o}, 32'd0, "R1 link in reset");
      @(negedge clk);
      rst_n = 1'b1;
      m_pc = RV;
      m_slot = 1'b0;
      m_tgt = '0;
      tn = 0;
   endtask

   // one issue cycle: drive, check combinational outputs, advance the model
   task automatic step(input logic [1:0] cls, input logic [25:0] idx, input logic [31:0] rs);
      logic [31:0] e_npc, slot_a;
      logic        hon, e_lwe, e_aerr;
      ctl_class_i = cls;
      jidx_i = idx;
      rs_val_i = rs;
      #1;
      hon    = !m_slot;
      slot_a = m_pc + 32'd4;
      e_npc  = m_slot ? m_tgt : slot_a;
      e_lwe  = hon && cls == 2'd2;
      e_aerr = hon && cls == 2'd3 && rs[1:0] != 2'b00;
      if (tn < 16) trace[tn] = pc_o;
      tn++;
      chk(pc_o, m_pc, "R3 fetch order");
      chk({31'd0, in_slot_o}, {31'd0, m_slot}, "R3 slot flag");
      chk(npc_o, e_npc, m_slot ? "R3 next after slot" : "R2 next pc");
      chk({31'd0, link_we_o}, {31'd0, e_lwe}, m_slot ? "R8 link in slot" : "R5 link enable");
      if (e_lwe) begin
         chk(link_val_o, m_pc + 32'd8, "R5 link value");
         chk({27'd0, link_addr_o}, 32'd31, "R5 link register");
      end
      chk({31'd0, align_err_o}, {31'd0, e_aerr}, m_slot ? "R8 align in slot" : "R7 align flag");
      if (hon && cls != 2'd0) begin
         m_tgt  = (cls == 2'd3) ? rs : {slot_a[31:28], idx, 2'b00};
         m_slot = 1'b1;
      end else begin
         m_slot = 1'b0;
      end
      m_pc = e_npc;
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] lv, jal_at;
      int seen;
      m_pc = RV; m_slot = 0; m_tgt = 0; tn = 0;
      #2;
      do_reset();

      // every 3-instruction class sequence (R2, R3, R4, R5, R8)
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) begin
               do_reset();
               step(2'(a), 26'(a * 4099 + 17), 32'h0000_1000 + 32'(a * 64 + b));
               step(2'(b), 26'(b * 263 + 5), 32'h0002_0000 + 32'(b * 16 + c));
               step(2'(c), 26'(c * 31 + 9), 32'h0030_0000 + 32'(c * 4));
               step(2'd0, 26'd0, 32'd0);
               step(2'd0, 26'd0, 32'd0);
            end

      // R4: jump in the last word of a region takes upper bits from the slot
      do_reset();
      step(2'd3, 26'd0, 32'h0FFF_FFF8);
      step(2'd0, 26'd0, 32'd0);
      step(2'd0, 26'd0, 32'd0);
      chk(pc_o, 32'h0FFF_FFFC, "R4 setup");
      step(2'd1, 26'd5, 32'd0);
      chk(pc_o, 32'h1000_0000, "R4 slot crosses region");
      step(2'd0, 26'd0, 32'd0);
      chk(pc_o, 32'h1000_0014, "R4 target region from slot");

      // R6: register changed during slot is ignored; R7: all low-bit patterns
      for (int lb = 0; lb < 4; lb++) begin
         do_reset();
         step(2'd3, 26'd0, 32'h0000_2000 + 32'(lb));
         step(2'd0, 26'd0, 32'h0000_9990);
         chk(pc_o, 32'h0000_2000 + 32'(lb), "R6 R7 register target kept");
      end

      // R8: control classes inside the slot are not honored
      do_reset();
      step(2'd1, 26'h10, 32'd0);
      step(2'd2, 26'h77, 32'h0000_5000);
      chk(pc_o, {RV[31:28], 26'h10, 2'b00}, "R8 slot jump ignored");
      step(2'd3, 26'd0, 32'h0000_6002);
      step(2'd0, 26'd0, 32'd0);
      chk(pc_o, 32'h0000_6002, "R8 flow after slot");

      // R9: return through link value skips the delay slot
      do_reset();
      step(2'd0, 26'd0, 32'd0);
      step(2'd0, 26'd0, 32'd0);
      jal_at = pc_o;
      lv = link_val_o;
      step(2'd2, 26'h100, 32'd0);
      step(2'd0, 26'd0, 32'd0);
      step(2'd0, 26'd0, 32'd0);
      step(2'd3, 26'd0, lv);
      step(2'd0, 26'd0, 32'd0);
      chk(pc_o, jal_at + 32'd8, "R9 return address");
      seen = 0;
      for (int i = 0; i < tn && i < 16; i++)
         if (trace[i] == jal_at + 32'd4) seen++;
      chk(32'(seen), 32'd1, "R9 R3 slot issued once");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule